// File: doc/BRIEF.md
# Burst-Gated Serial Bitstream Transmitter

This block takes 32-bit words from a valid/ready source and shifts them out, most significant bit first, on a single data line. It generates its own serial bit clock by dividing the system clock. The data line changes when the bit clock returns to its rest level. A receiver samples it when the clock leaves that level. Two modes are available. In streaming mode the bit clock keeps running once the first word has started, and words follow one another with nothing to mark where a word begins. In burst mode the bit clock runs only while there is a word to send, and it rests at a selectable level otherwise.

One word can wait in a holding register while the current word shifts, so a source that keeps up sees no gaps. In streaming mode a word boundary with nothing waiting is filled with one word of zeros, and a sticky underrun flag is raised. A mute control forces the data line low without changing the clock.

A single FSM in the shifter sets the behaviour, with three states:

- `ST_IDLE`: the clock is stopped at rest.
- `ST_SEND`: a real word is shifting.
- `ST_FILL`: a zero word is shifting after starvation.

Its named transitions are:

- T_START: `ST_IDLE` to `ST_SEND`, when a word is held.
- T_CHAIN: `ST_SEND` or `ST_FILL` to `ST_SEND`, at a word end with a word held.
- T_STOP: `ST_SEND` or `ST_FILL` to `ST_IDLE`, at a word end with nothing held in burst mode.
- T_STARVE: `ST_SEND` or `ST_FILL` to `ST_FILL`, at a word end with nothing held in streaming mode.

Top module: `bitstream_tx`

## Requirements
- R1: Each word is sent as 32 bits, bit 31 first and bit 0 last, and words leave in the order they were accepted.
- R2: In streaming mode (`burst_en`=0), words that are supplied in time follow each other with no extra bit clock pause between words.
- R3: In burst mode (`burst_en`=1), the bit clock makes exactly 32 pulses per accepted word and then stops.
- R4: In burst mode, a word already held when a word ends continues without any pause longer than a normal half bit.
- R5: While stopped, `sck` equals `idle_high`: low for 0, high for 1.
- R6: `sdata` stays constant during the whole active half of each bit, so it changes only on the active-to-rest edge of `sck`.
- R7: Each half of a bit, active or rest, lasts `half_period`+1 system clock cycles.
- R8: With `mute`=1, `sdata` is 0 for every bit, and the bit clock pulse count and timing are unchanged.
- R9: In streaming mode, a word end with no word held sends 32 zero bits with the clock running and sets `underrun`, which stays set until reset.
- R10: `word_ready` is 1 exactly when the holding register is empty. After a word is accepted, `word_ready` is 0 until the shifter takes that word.
- R11: Synchronous reset (`rst`=1) discards the word in progress and any held word. It puts `sck` at rest, drives `sdata` to 0, sets `word_ready` to 1 and clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| word_data | input | 32 | Word to transmit, bit 31 sent first |
| word_valid | input | 1 | Source offers `word_data` |
| word_ready | output | 1 | Holding register empty; a word is taken when valid and ready |
| burst_en | input | 1 | 1 = burst mode, 0 = streaming mode |
| idle_high | input | 1 | Rest level of `sck` |
| mute | input | 1 | 1 = data line forced to 0 |
| half_period | input | 8 | Half bit length minus one, in system clocks |
| sck | output | 1 | Generated serial bit clock |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky streaming starvation flag |

## Verification
Two kinds of internal fault show up on the line with little delay.

- A bit counter or shift register that slips changes the sampled bit sequence. The first wrong bit appears within one bit time of the fault, and the pulse count of a burst word is off by the end of that word.
- A fault in the divider or the phase register shows up within one half bit. It changes how long a clock phase lasts, or it makes `sdata` move while `sck` is active.

Some faults are only visible once the word in flight ends:

- A lost held word.
- A wrong decision at a word end.
- A stale underrun flag.

Each of these shows within one word time, as a missing word, a clock that does not stop or does not pause, a missing zero fill, or a wrong flag.

// File: rtl/bst_pkg.sv
package bst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FILL = 2'd2
    } tx_state_t;
endpackage

// File: rtl/bst_divider.sv
module bst_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= half_period) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q >= half_period);

    // A half phase longer than one cycle never produces two ticks in a row
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && half_period != '0 && $stable(half_period)) |=> !tick);
endmodule

// File: rtl/bst_holder.sv
module bst_holder #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              hold_valid,
    output logic [WORD_W-1:0] hold_data
);
    logic              valid_q;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (take) begin
            valid_q <= 1'b0;
        end else if (in_valid && !valid_q) begin
            valid_q <= 1'b1;
            data_q  <= in_data;
        end
    end

    assign in_ready   = !valid_q;
    assign hold_valid = valid_q;
    assign hold_data  = data_q;

    // A held word stays intact until the shifter takes it
    assert_hold_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !take) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/bst_shifter.sv
module bst_shifter
    import bst_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              burst_en,
    input  logic              hold_valid,
    input  logic [WORD_W-1:0] hold_data,
    output logic              take,
    output tx_state_t         state,
    output logic              phase,
    output logic              data_bit,
    output logic              underrun
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    tx_state_t         state_q, state_d;
    logic              ph_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              underrun_q;
    logic              word_end;
    logic              starve;

    // next-state logic with named transitions
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        starve   = 1'b0;
        word_end = (state_q != ST_IDLE) && tick && ph_q && (bit_cnt_q == LAST_BIT);
        unique case (state_q)
            ST_IDLE: begin
                if (hold_valid) begin              // T_START
                    state_d = ST_SEND;
                    take    = 1'b1;
                end
            end
            ST_SEND, ST_FILL: begin
                if (word_end) begin
                    if (hold_valid) begin          // T_CHAIN
                        state_d = ST_SEND;
                        take    = 1'b1;
                    end else if (burst_en) begin   // T_STOP
                        state_d = ST_IDLE;
                    end else begin                 // T_STARVE
                        state_d = ST_FILL;
                        starve  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit phase, counter and shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= 1'b0;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            underrun_q <= 1'b0;
        end else begin
            if (starve) begin
                underrun_q <= 1'b1;
            end
            if (take) begin
                shreg_q   <= hold_data;
                bit_cnt_q <= '0;
                ph_q      <= 1'b0;
            end else if (starve) begin
                shreg_q   <= '0;
                bit_cnt_q <= '0;
                ph_q      <= 1'b0;
            end else if (state_d == ST_IDLE) begin
                ph_q      <= 1'b0;
            end else if (state_q != ST_IDLE && tick) begin
                if (!ph_q) begin
                    ph_q <= 1'b1;
                end else begin
                    ph_q      <= 1'b0;
                    shreg_q   <= {shreg_q[WORD_W-2:0], 1'b0};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        phase    = ph_q;
        underrun = underrun_q;
        data_bit = (state_q == ST_SEND) ? shreg_q[WORD_W-1] : 1'b0;
    end

    assert_shift_still_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && ph_q && !tick) |=> $stable(shreg_q));
    assert_burst_halts_R3: assert property (@(posedge clk) disable iff (rst)
        (word_end && !hold_valid && burst_en) |=> (state_q == ST_IDLE && !ph_q));
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        underrun_q |=> underrun_q);
    assert_fill_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> (shreg_q == '0));
endmodule

// File: rtl/bitstream_tx.sv
module bitstream_tx
    import bst_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic              burst_en,
    input  logic              idle_high,
    input  logic              mute,
    input  logic [DIV_W-1:0]  half_period,
    output logic              sck,
    output logic              sdata,
    output logic              underrun
);
    logic              tick;
    logic              take;
    logic              hold_valid;
    logic [WORD_W-1:0] hold_data;
    tx_state_t         state;
    logic              phase;
    logic              data_bit;

    bst_divider #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .run         (state != ST_IDLE),
        .half_period (half_period),
        .tick        (tick)
    );

    bst_holder #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .in_data    (word_data),
        .in_valid   (word_valid),
        .in_ready   (word_ready),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    bst_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .burst_en   (burst_en),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .take       (take),
        .state      (state),
        .phase      (phase),
        .data_bit   (data_bit),
        .underrun   (underrun)
    );

    assign sck   = idle_high ^ phase;
    assign sdata = data_bit & ~mute;

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (sck == idle_high));
    assert_mute_low_R8: assert property (@(posedge clk) disable iff (rst)
        mute |-> !sdata);
endmodule

// File: tb/test_bitstream_tx.sv
`timescale 1ns/1ps
module test_bitstream_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic        burst_en = 1'b0;
    logic        idle_high = 1'b0;
    logic        mute = 1'b0;
    logic [7:0]  half_period = '0;
    logic        sck, sdata, underrun;

    int checks = 0;
    int errors = 0;

    bitstream_tx i_bitstream_tx (
        .clk(clk), .rst(rst), .word_data(word_data), .word_valid(word_valid),
        .word_ready(word_ready), .burst_en(burst_en), .idle_high(idle_high),
        .mute(mute), .half_period(half_period), .sck(sck), .sdata(sdata),
        .underrun(underrun)
    );

    always #2 clk = ~clk;

    // line monitor: records bits at rest-to-active edges, phase lengths, gaps
    logic rx_bits [0:255];
    int   rx_n, act_len, idle_len, max_gap, r6_bad, r7_bad;
    logic prev_act, prev_sd;
    always @(negedge clk) begin
        if (rst) begin
            rx_n = 0; act_len = 0; idle_len = 0; max_gap = 0;
            r6_bad = 0; r7_bad = 0; prev_act = 1'b0; prev_sd = 1'b0;
        end else begin
            if (sck !== idle_high) begin
                if (!prev_act) begin
                    if (rx_n > 0 && idle_len > max_gap) max_gap = idle_len;
                    idle_len = 0;
                    if (rx_n < 256) rx_bits[rx_n] = sdata;
                    rx_n++;
                    act_len = 1;
                end else begin
                    act_len++;
                    if (sdata !== prev_sd) r6_bad++;
                end
                prev_act = 1'b1;
            end else begin
                if (prev_act && act_len != int'(half_period) + 1) r7_bad++;
                idle_len++;
                prev_act = 1'b0;
            end
            prev_sd = sdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_bits(input int n);
        for (int t = 0; t < 20000 && rx_n < n; t++) @(negedge clk);
    endtask

    function automatic logic [31:0] rx_word(input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++) w = {w[30:0], rx_bits[k*32 + b]};
        return w;
    endfunction

    task automatic send_word(input logic [31:0] w);
        while (!word_ready) @(negedge clk);
        word_data = w;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        // R10: accepted word occupies the holding register
        chk(word_ready == 1'b0, "R10 ready after accept", {31'd0, word_ready}, 32'd0);
    endtask

    task automatic run_cfg(input bit bm, input bit pol, input int hp, input bit mu);
        logic [31:0] words [0:2];
        logic [31:0] exp;
        burst_en = bm; idle_high = pol; half_period = 8'(hp); mute = mu;
        do_reset();
        // R11 / R5: reset state
        chk(sck == pol && sdata == 1'b0 && word_ready && !underrun, "R11 reset state",
            {28'd0, sck, sdata, word_ready, underrun}, {28'd0, pol, 1'b0, 1'b1, 1'b0});
        for (int k = 0; k < 3; k++)
            words[k] = 32'h8E3C_A561 ^ (32'h1357_9BDF * (k + 1)) ^ {16'd0, 8'(hp), 6'd0, pol, bm};
        for (int k = 0; k < 3; k++) send_word(words[k]);
        wait_bits(96);
        for (int k = 0; k < 3; k++) begin
            exp = mu ? 32'd0 : words[k];
            chk(rx_word(k) == exp, mu ? "R8 muted word" : "R1 word bits", rx_word(k), exp);
        end
        if (bm) begin
            repeat (8 * (hp + 1) + 20) @(negedge clk);
            chk(rx_n == 96, "R3 burst pulse count", rx_n, 96);
            chk(sck == pol, "R5 rest level after burst", {31'd0, sck}, {31'd0, pol});
            chk(max_gap <= hp + 1, "R4 no pause between held words", max_gap, hp + 1);
            chk(underrun == 1'b0, "R3 no underrun in burst", {31'd0, underrun}, 32'd0);
        end else begin
            chk(max_gap <= hp + 1, "R2 continuous stream", max_gap, hp + 1);
            wait_bits(128);
            chk(rx_word(3) == 32'd0, "R9 zero fill word", rx_word(3), 32'd0);
            chk(underrun == 1'b1, "R9 underrun set", {31'd0, underrun}, 32'd1);
            chk(max_gap <= hp + 1, "R9 clock keeps running", max_gap, hp + 1);
        end
        chk(r6_bad == 0, "R6 data stable while active", r6_bad, 0);
        chk(r7_bad == 0, "R7 half phase length", r7_bad, 0);
    endtask

    task automatic run_all();
        for (int bm = 0; bm < 2; bm++)
            for (int pol = 0; pol < 2; pol++)
                for (int hp = 0; hp < 3; hp++)
                    for (int mu = 0; mu < 2; mu++)
                        run_cfg(bm[0], pol[0], hp, mu[0]);
        // R11: reset mid-word after underrun, with a word held
        burst_en = 1'b0; idle_high = 1'b1; half_period = 8'd1; mute = 1'b0;
        do_reset();
        send_word(32'hFFFF_FFFF);
        wait_bits(40);
        send_word(32'hFFFF_0000);
        wait_bits(42);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(sck == 1'b1 && sdata == 1'b0 && word_ready && !underrun, "R11 reset mid-word",
            {29'd0, sck, sdata, word_ready}, {29'd0, 1'b1, 1'b0, 1'b1});
        chk(underrun == 1'b0, "R11 underrun cleared", {31'd0, underrun}, 32'd0);
        repeat (300) @(negedge clk);
        chk(rx_n == 0, "R11 held word discarded", rx_n, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (180000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual running expected done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule